// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Read Port

A single-clock first-in first-out buffer whose read side is chosen at build time to behave in one of two ways. In standard mode the read enable is a request: the reader asks for a word and gets it on the data output after the next rising edge, marked by a one-cycle valid pulse. In fall-through (look-ahead) mode the oldest word is placed on the data output without being asked for, and the read enable becomes an acknowledge that retires that word and brings up the next one.

Words are stored in an inferred RAM with a registered read port. In fall-through mode a second register, the presentation stage, sits after the RAM read register, so the output is always a flop and never a combinational path through the RAM. Because of that pipeline, a word written into an empty fall-through FIFO reaches the output exactly two edges after the edge that stored it. The occupancy used for the full flag counts every accepted word not yet consumed, including those sitting in the read pipeline. Reset is synchronous and active low.

Top module: `fifo_dual_rd`

## Requirements
- R1: One edge with rst_ni low leaves empty_o high, full_o low, valid_o low and rd_data_o equal to zero, in both modes.
- R2: In standard mode (MODE = RD_STD, encoded 0), rd_en_i high while empty_o is low puts the oldest word on rd_data_o after the next rising edge, with valid_o high for exactly that one cycle; rd_data_o holds its value until the next accepted read.
- R3: In fall-through mode (MODE = RD_FWFT, encoded 1), a word written into an empty FIFO appears on rd_data_o with no read request, and empty_o falls exactly two rising edges after the edge that sampled the write; valid_o always equals the inverse of empty_o.
- R4: In fall-through mode, rd_en_i high while empty_o is low retires the presented word, and after that edge the next stored word is on rd_data_o; reads on consecutive cycles retire one word per cycle.
- R5: In fall-through mode, empty_o rises only on the edge that retires the last presented word; while words remain it stays low.
- R6: The occupancy counts every accepted, unconsumed word, including the words in the read pipeline; full_o is high exactly when it equals DEPTH, and a write while full_o is high stores nothing.
- R7: A read while empty_o is high is ignored: rd_data_o, valid_o, empty_o and the read position are unchanged, so the next word written is the next word read.
- R8: A read and a write accepted in the same cycle keep the occupancy unchanged and keep first-in first-out order.
- R9: Words leave in the order they were written, in both modes, across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, ignored while full_o is high |
| wr_data_i | input | DATA_W | Write data |
| full_o | output | 1 | Occupancy equals DEPTH |
| rd_en_i | input | 1 | Read request (standard) or acknowledge (fall-through) |
| rd_data_o | output | DATA_W | Read data |
| empty_o | output | 1 | No word available to the reader |
| valid_o | output | 1 | Standard: one-cycle pulse per returned word; fall-through: rd_data_o holds a live word |

## Verification
The bench times the fall-through first-word latency to the exact edge, so a design that presents the word after one edge or after three fails, as does one that needs a read request to start. It fills the buffer to DEPTH, pushes one more word and drains it, so a design that ignores the pipeline words in its count would overrun and hand back an extra word or a corrupted order. It hammers an empty FIFO with reads and then writes one word, catching a design whose pointer slips or whose output changes on an ignored read. Concurrent read and write at a steady level catches a design that loses or duplicates a word when both strobes meet.

// File: rtl/fifo_rd_pkg.sv
package fifo_rd_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/fifo_rd_ram.sv
module fifo_rd_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  // registered read port; only the output flop is reset
  always_ff @(posedge clk_i) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/fifo_rd_ptrs.sv
module fifo_rd_ptrs #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          ram_rd_i,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          ram_avail_o,
  output logic          full_o,
  output logic          occ_empty_o
);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] ram_cnt_q;  // words still in the RAM array
  logic [CW-1:0] occ_q;      // words accepted and not yet consumed

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      ram_cnt_q <= '0;
      occ_q     <= '0;
    end else begin
      if (push_i)   wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (ram_rd_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, ram_rd_i})
        2'b10:   ram_cnt_q <= ram_cnt_q + 1'b1;
        2'b01:   ram_cnt_q <= ram_cnt_q - 1'b1;
        default: ram_cnt_q <= ram_cnt_q;
      endcase
      case ({push_i, pop_i})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign waddr_o     = wr_ptr_q;
  assign raddr_o     = rd_ptr_q;
  assign ram_avail_o = (ram_cnt_q != '0);
  assign full_o      = (occ_q == DEPTH_C);
  assign occ_empty_o = (occ_q == '0);
endmodule

// File: rtl/fifo_rd_prefetch.sv
module fifo_rd_prefetch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ram_avail_i,
  input  logic [DATA_W-1:0] ram_q_i,
  input  logic              take_i,
  output logic              ram_rd_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  logic              s1_v_q;   // RAM read register holds a word
  logic              out_v_q;
  logic [DATA_W-1:0] out_q;
  logic              s1_mv;

  assign s1_mv    = s1_v_q & (~out_v_q | take_i);
  assign ram_rd_o = ram_avail_i & (~s1_v_q | s1_mv);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      s1_v_q  <= 1'b0;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      s1_v_q <= ram_rd_o | (s1_v_q & ~s1_mv);
      if (s1_mv) begin
        out_q   <= ram_q_i;
        out_v_q <= 1'b1;
      end else if (take_i) begin
        out_v_q <= 1'b0;
      end
    end
  end

  assign data_o  = out_q;
  assign valid_o = out_v_q;
endmodule

// File: rtl/fifo_dual_rd.sv
module fifo_dual_rd #(
  parameter int                   DATA_W = 8,
  parameter int                   DEPTH  = 256,
  parameter fifo_rd_pkg::rd_mode_e MODE  = fifo_rd_pkg::RD_FWFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              valid_o
);
  localparam int AW = $clog2(DEPTH);

  logic              wr_ok, rd_ok, ram_rd, ram_avail, occ_empty;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] ram_q;

  assign wr_ok = wr_en_i & ~full_o;
  assign rd_ok = rd_en_i & ~empty_o;

  fifo_rd_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ram (
    .clk_i, .rst_ni,
    .we_i(wr_ok), .waddr_i(waddr), .wdata_i(wr_data_i),
    .re_i(ram_rd), .raddr_i(raddr), .rdata_o(ram_q)
  );

  fifo_rd_ptrs #(.DEPTH(DEPTH)) i_ptrs (
    .clk_i, .rst_ni,
    .push_i(wr_ok), .pop_i(rd_ok), .ram_rd_i(ram_rd),
    .waddr_o(waddr), .raddr_o(raddr), .ram_avail_o(ram_avail),
    .full_o(full_o), .occ_empty_o(occ_empty)
  );

  generate
    if (MODE == fifo_rd_pkg::RD_FWFT) begin : g_fwft
      logic pf_valid;
      fifo_rd_prefetch #(.DATA_W(DATA_W)) i_pf (
        .clk_i, .rst_ni,
        .ram_avail_i(ram_avail), .ram_q_i(ram_q), .take_i(rd_ok),
        .ram_rd_o(ram_rd), .data_o(rd_data_o), .valid_o(pf_valid)
      );
      assign empty_o = ~pf_valid;
      assign valid_o = pf_valid;
    end else begin : g_std
      logic vld_q;
      assign ram_rd = rd_ok;
      always_ff @(posedge clk_i) begin
        if (!rst_ni) vld_q <= 1'b0;
        else         vld_q <= rd_ok;
      end
      assign empty_o   = occ_empty;
      assign valid_o   = vld_q;
      assign rd_data_o = ram_q;
      logic unused_avail;
      assign unused_avail = ram_avail;
    end
  endgenerate
endmodule

// File: rtl/fifo_dual_rd_chk.sv
module fifo_dual_rd_chk #(
  parameter int                    DATA_W = 8,
  parameter int                    DEPTH  = 256,
  parameter fifo_rd_pkg::rd_mode_e MODE   = fifo_rd_pkg::RD_FWFT
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              full_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              empty_o,
  input logic              valid_o
);
  a_r1_reset_state: assert property (@(posedge clk_i)
    !rst_ni |=> (empty_o && !full_o && !valid_o && rd_data_o == '0));

  a_r6_full_excl_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r6_full_write_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_en_i && !rd_en_i) |=> full_o);

  generate
    if (MODE == fifo_rd_pkg::RD_FWFT) begin : g_fwft
      a_r3_valid_is_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == !empty_o);
      a_r5_empty_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!empty_o && !rd_en_i) |=> !empty_o);
      a_r4_held_without_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!empty_o && !rd_en_i) |=> $stable(rd_data_o));
    end else begin : g_std
      a_r2_valid_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !empty_o) |=> valid_o);
      a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_en_i && !empty_o) |=> !valid_o);
      a_r7_empty_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (empty_o && rd_en_i) |=> ($stable(rd_data_o) && !valid_o));
    end
  endgenerate

  logic unused_wd;
  assign unused_wd = ^wr_data_i;
endmodule

bind fifo_dual_rd fifo_dual_rd_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .MODE(MODE)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .full_o(full_o), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
  .empty_o(empty_o), .valid_o(valid_o)
);

// File: tb/test_fifo_dual_rd.sv
module test_fifo_dual_rd;
  localparam int DW = 8;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [DW-1:0] wd = '0;
  logic f_full, f_empty, f_valid, s_full, s_empty, s_valid;
  logic [DW-1:0] f_data, s_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fifo_dual_rd #(.DATA_W(DW), .DEPTH(DEPTH), .MODE(fifo_rd_pkg::RD_FWFT)) i_fifo_dual_rd (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .full_o(f_full),
    .rd_en_i(re), .rd_data_o(f_data), .empty_o(f_empty), .valid_o(f_valid));

  fifo_dual_rd #(.DATA_W(DW), .DEPTH(DEPTH), .MODE(fifo_rd_pkg::RD_STD)) i_fifo_dual_rd_std (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .full_o(s_full),
    .rd_en_i(re), .rd_data_o(s_data), .empty_o(s_empty), .valid_o(s_valid));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive for one edge, then sample 1 ns after it
  task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r);
    we = w; wd = d; re = r;
    @(posedge clk); #1;
    we = 1'b0; re = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 fwft empty", f_empty, 1); chk("R1 fwft full", f_full, 0);
    chk("R1 fwft valid", f_valid, 0); chk("R1 fwft data", f_data, 0);
    chk("R1 std empty", s_empty, 1); chk("R1 std full", s_full, 0);
    chk("R1 std valid", s_valid, 0); chk("R1 std data", s_data, 0);
  endtask

  task automatic t_fwft_first_word();
    do_reset();
    cyc(1, 8'hA5, 0);
    chk("R3 empty after write edge", f_empty, 1);
    cyc(0, 0, 0);
    chk("R3 empty after edge 1", f_empty, 1);
    chk("R3 valid tracks empty", f_valid, 0);
    cyc(0, 0, 0);
    chk("R3 empty after edge 2", f_empty, 0);
    chk("R3 valid after edge 2", f_valid, 1);
    chk("R3 data presented", f_data, 8'hA5);
    cyc(0, 0, 0);
    chk("R3 word held without read", f_data, 8'hA5);
  endtask

  task automatic t_fwft_stream();
    do_reset();
    for (int k = 0; k < 4; k++) cyc(1, 8'h10 + DW'(k), 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R4 first presented", f_data, 8'h10);
    for (int k = 1; k < 4; k++) begin
      cyc(0, 0, 1);
      chk("R4 next word after ack", f_data, 8'h10 + k);
      chk("R5 not empty with words left", f_empty, 0);
    end
    cyc(0, 0, 1);
    chk("R5 empty after last ack", f_empty, 1);
    chk("R5 valid low when empty", f_valid, 0);
  endtask

  task automatic t_std_read();
    do_reset();
    cyc(1, 8'h20, 0); cyc(1, 8'h21, 0); cyc(0, 0, 0);
    chk("R2 not empty", s_empty, 0);
    chk("R2 no valid without read", s_valid, 0);
    cyc(0, 0, 1);
    chk("R2 data one edge after request", s_data, 8'h20);
    chk("R2 valid pulse", s_valid, 1);
    cyc(0, 0, 0);
    chk("R2 valid one cycle only", s_valid, 0);
    chk("R2 data held", s_data, 8'h20);
    cyc(0, 0, 1);
    chk("R9 std order", s_data, 8'h21);
    chk("R2 std empty after last", s_empty, 1);
  endtask

  task automatic t_empty_read();
    do_reset();
    cyc(1, 8'h33, 0); cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 1);
    chk("R7 std got word", s_data, 8'h33);
    chk("R7 fwft empty", f_empty, 1);
    for (int k = 0; k < 3; k++) cyc(0, 0, 1);
    chk("R7 std data unchanged", s_data, 8'h33);
    chk("R7 std valid low", s_valid, 0);
    chk("R7 std still empty", s_empty, 1);
    chk("R7 fwft data unchanged", f_data, 8'h33);
    chk("R7 fwft valid low", f_valid, 0);
    chk("R7 fwft still empty", f_empty, 1);
    cyc(1, 8'h44, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R7 fwft next word after ignored reads", f_data, 8'h44);
    chk("R7 fwft not empty", f_empty, 0);
    cyc(0, 0, 1);
    chk("R7 std next word after ignored reads", s_data, 8'h44);
  endtask

  task automatic t_full();
    int bad_f = 0, bad_s = 0;
    do_reset();
    for (int k = 0; k < DEPTH - 1; k++) cyc(1, DW'(k), 0);
    chk("R6 fwft not full at DEPTH-1", f_full, 0);
    chk("R6 std not full at DEPTH-1", s_full, 0);
    cyc(1, DW'(DEPTH - 1), 0);
    chk("R6 fwft full at DEPTH", f_full, 1);
    chk("R6 std full at DEPTH", s_full, 1);
    cyc(1, 8'hEE, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    chk("R6 fwft full held", f_full, 1);
    for (int k = 0; k < DEPTH; k++) begin
      if (f_data !== DW'(k) || f_empty !== 1'b0) bad_f++;
      cyc(0, 0, 1);
      if (s_data !== DW'(k) || s_valid !== 1'b1) bad_s++;
      if (k == 0) chk("R6 full drops after one read", f_full, 0);
    end
    chk("R9 fwft drain order", bad_f, 0);
    chk("R9 std drain order", bad_s, 0);
    chk("R6 fwft empty, write when full dropped", f_empty, 1);
    chk("R6 std empty, write when full dropped", s_empty, 1);
  endtask

  task automatic t_simul();
    logic [DW-1:0] f_exp [4] = '{8'h51, 8'h52, 8'h60, 8'h61};
    logic [DW-1:0] s_exp [4] = '{8'h50, 8'h51, 8'h52, 8'h60};
    do_reset();
    cyc(1, 8'h50, 0); cyc(1, 8'h51, 0); cyc(1, 8'h52, 0);
    cyc(0, 0, 0); cyc(0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(1, 8'h60 + DW'(k), 1);
      chk("R8 fwft order under read+write", f_data, f_exp[k]);
      chk("R8 std order under read+write", s_data, s_exp[k]);
      chk("R8 fwft never empty", f_empty, 0);
      chk("R8 std never empty", s_empty, 0);
    end
    cyc(0, 0, 1);
    chk("R8 std drain 1", s_data, 8'h61);
    cyc(0, 0, 1);
    chk("R8 std drain 2", s_data, 8'h62);
    chk("R8 fwft occupancy kept", f_empty, 0);
    chk("R8 std occupancy kept", s_empty, 0);
    cyc(0, 0, 1);
    chk("R8 std drain 3", s_data, 8'h63);
    chk("R8 std empty after 3", s_empty, 1);
    chk("R8 fwft empty after 3", f_empty, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fwft_first_word();
    t_fwft_stream();
    t_std_read();
    t_empty_read();
    t_full();
    t_simul();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule